// File: doc/BRIEF.md
# Double-Buffered Timer PWM Generator

This block produces pulse-width-modulated outputs for a set of channels that share a single 8-bit period timer. Software programs it through a simple register-write port. It sets the timer count, the period limit and the timer control (run enable and prescale). For each channel it also sets a duty byte and a control byte; the control byte carries the channel mode and the two least significant duty bits. Every channel compares a 10-bit duty value against the timer count. That count is extended below its least significant bit by two phase bits taken from the prescaler.

A period ends when the timer count equals the period limit on a timer step. At that step the timer returns to zero, a sticky flag is raised, and each channel in PWM mode drives its pin high. At the same step each channel copies its software-written duty into an active copy, so a duty change never alters a cycle already under way. Writes to the timer count or the period limit act at once. A count that ends up above the limit runs on through 0xFF and wraps before it matches.

Top module: `dbpwm_top`

Address map (4-bit address, 8-bit data): 0 = timer count, 1 = period limit, 2 = timer control, 3 = flag clear (any data), 4 + 2·c = duty byte of channel c, 5 + 2·c = control byte of channel c.

## Requirements
- R1: After reset every register is 0, the timer is stopped, all PWM pins are low and the period flag is low; with the timer stopped no pin ever rises.
- R2: Timer control bit 2 runs the timer and bits 1:0 select the prescale (00 = 1, 01 = 4, 10 or 11 = 16); the timer advances by one every 4 × prescale clocks, and the two phase bits are the matching 2-bit slice of the prescaler counter; while stopped the count holds.
- R3: When the timer steps while its count equals the period limit P, the count returns to 0 instead of incrementing, so one cycle lasts (P + 1) × 4 × prescale clocks.
- R4: The period flag rises on the clock after every period boundary and stays high until a write to address 3; a clear that lands on a boundary cycle leaves the flag set.
- R5: A channel is in PWM mode when its control byte bits 3:2 are 11; its duty D is {duty byte, control bits 5:4}; its pin rises at each boundary and falls once the extended count reaches D, giving D × prescale clocks high.
- R6: The active duty is copied from the written duty byte and control bits 5:4 only at a period boundary; a duty write mid-cycle changes the following cycle, not the current one.
- R7: Channels share the timer and the period limit but hold independent duty values and modes; changing one channel leaves the others unchanged.
- R8: A write to the timer count replaces the count from the next clock and clears the prescaler; pins hold their levels until a compare or boundary actually occurs, so a channel whose duty point is jumped over stays at its level until the next boundary.
- R9: A write to the period limit is used by the very next comparison; if the limit is set below the current count, the timer counts on, wraps from 0xFF to 0 and then matches.
- R10: A duty above the extended period keeps the pin high for the whole cycle; a duty of 0 keeps the pin low, with no high pulse at the boundary.
- R11: A channel whose control bits 3:2 are not 11 (including a control byte of 0) drives its pin low from the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register address |
| wr_data | input | 8 | Register write data |
| pwm_out | output | NUM_CH (2) | One PWM pin per channel |
| period_flag | output | 1 | Sticky period-boundary flag |

## Verification
Every register write takes effect on the clock edge that samples it, so pins and the flag reflect it one edge later. A boundary shows as a high pin and a set flag one edge after the timer step at the limit, and a pin falls one edge after the extended count reaches its duty. The bench keeps a cycle-level reference model that is updated at each rising edge and compared with both outputs at every falling edge. Directed checks count falling edges from a resynchronising rising pin edge; in this way the expected high times, cycle lengths and wrap distances (D × prescale, (P + 1) × 4 × prescale, 1010 clocks for the wrap case) are checked at exactly the edge where each result is due.

// File: rtl/dbpwm_pkg.sv
package dbpwm_pkg;

    localparam int TMR_W      = 8;
    localparam int FRAC_W     = 2;
    localparam int DUTY_W     = TMR_W + FRAC_W;
    localparam int PS_SHIFT   = 4;                    // largest prescale is 2**PS_SHIFT
    localparam int PS_W       = FRAC_W + PS_SHIFT;
    localparam int DATA_W     = 8;
    localparam int CH_BASE    = 4;                    // first per-channel address

    localparam int ADR_TIMER  = 0;
    localparam int ADR_PERIOD = 1;
    localparam int ADR_TCTL   = 2;
    localparam int ADR_FCLR   = 3;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV4   = 2'b01,
        PS_DIV16  = 2'b10,
        PS_DIV16X = 2'b11
    } ps_sel_e;

    typedef struct packed {
        logic    run;
        ps_sel_e ps;
    } tctl_t;

    typedef struct packed {
        logic [1:0] duty_lo;
        logic [1:0] mode_hi;
        logic [1:0] mode_lo;
    } chctl_t;

    function automatic logic [PS_W-1:0] ps_limit(input ps_sel_e s);
        case (s)
            PS_DIV1: return PS_W'(3);
            PS_DIV4: return PS_W'(15);
            default: return PS_W'(63);
        endcase
    endfunction

    function automatic logic [FRAC_W-1:0] ps_phase(input ps_sel_e s,
                                                   input logic [PS_W-1:0] c);
        case (s)
            PS_DIV1: return c[1:0];
            PS_DIV4: return c[3:2];
            default: return c[5:4];
        endcase
    endfunction

    function automatic logic is_pwm(input chctl_t c);
        return c.mode_hi == 2'b11;
    endfunction

endpackage

// File: rtl/dbpwm_presc.sv
module dbpwm_presc
    import dbpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  tctl_t             ctl_q,
    input  ps_sel_e           ps_n,
    input  logic              clr,
    output logic              tick,
    output logic [FRAC_W-1:0] phase_n
);

    logic [PS_W-1:0] cnt_q, cnt_n, lim;

    always_comb begin
        lim  = ps_limit(ctl_q.ps);
        tick = ctl_q.run && !clr && (cnt_q == lim);
        if (clr)
            cnt_n = '0;
        else if (!ctl_q.run)
            cnt_n = cnt_q;
        else if (cnt_q == lim)
            cnt_n = '0;
        else
            cnt_n = cnt_q + PS_W'(1);
        phase_n = ps_phase(ps_n, cnt_n);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_n;
    end

endmodule

// File: rtl/dbpwm_timebase.sv
module dbpwm_timebase
    import dbpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             tmr_wr,
    input  logic             per_wr,
    input  logic             flag_clr,
    input  logic [TMR_W-1:0] wdata,
    output logic [TMR_W-1:0] tmr_q,
    output logic [TMR_W-1:0] tmr_n,
    output logic             boundary,
    output logic             flag_q
);

    logic [TMR_W-1:0] per_q, per_n;
    logic             at_limit, flag_n;

    always_comb begin
        at_limit = (tmr_q == per_q);
        boundary = tick && at_limit && !tmr_wr;

        if (tmr_wr)
            tmr_n = wdata;
        else if (tick)
            tmr_n = at_limit ? '0 : tmr_q + TMR_W'(1);
        else
            tmr_n = tmr_q;

        per_n = per_wr ? wdata : per_q;

        if (boundary)
            flag_n = 1'b1;
        else if (flag_clr)
            flag_n = 1'b0;
        else
            flag_n = flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q  <= '0;
            per_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            tmr_q  <= tmr_n;
            per_q  <= per_n;
            flag_q <= flag_n;
        end
    end

endmodule

// File: rtl/dbpwm_chan.sv
module dbpwm_chan
    import dbpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary,
    input  logic              duty_wr,
    input  logic              ctl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DUTY_W-1:0] fine_n,
    output logic              pwm_q,
    output logic [DUTY_W-1:0] act_q
);

    logic [TMR_W-1:0]  dbyte_q, dbyte_n;
    chctl_t            ctl_q, ctl_n;
    logic [DUTY_W-1:0] act_n;
    logic              pwm_n;

    always_comb begin
        dbyte_n = duty_wr ? wdata[TMR_W-1:0] : dbyte_q;
        ctl_n   = ctl_wr ? chctl_t'(wdata[5:0]) : ctl_q;
        act_n   = boundary ? {dbyte_q, ctl_q.duty_lo} : act_q;

        if (!is_pwm(ctl_n))
            pwm_n = 1'b0;
        else if (fine_n == act_n)
            pwm_n = 1'b0;
        else if (boundary)
            pwm_n = 1'b1;
        else
            pwm_n = pwm_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dbyte_q <= '0;
            ctl_q   <= '0;
            act_q   <= '0;
            pwm_q   <= 1'b0;
        end else begin
            dbyte_q <= dbyte_n;
            ctl_q   <= ctl_n;
            act_q   <= act_n;
            pwm_q   <= pwm_n;
        end
    end

endmodule

// File: rtl/dbpwm_top.sv
module dbpwm_top
    import dbpwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [NUM_CH-1:0] pwm_out,
    output logic              period_flag
);

    logic tmr_wr, per_wr, tctl_wr, fclr_wr;
    logic [NUM_CH-1:0] duty_wr, ctl_wr;

    assign tmr_wr  = wr_en && (wr_addr == ADDR_W'(ADR_TIMER));
    assign per_wr  = wr_en && (wr_addr == ADDR_W'(ADR_PERIOD));
    assign tctl_wr = wr_en && (wr_addr == ADDR_W'(ADR_TCTL));
    assign fclr_wr = wr_en && (wr_addr == ADDR_W'(ADR_FCLR));

    tctl_t tctl_q, tctl_n;

    assign tctl_n = tctl_wr ? tctl_t'(wr_data[2:0]) : tctl_q;

    always_ff @(posedge clk) begin
        if (rst)
            tctl_q <= '0;
        else
            tctl_q <= tctl_n;
    end

    logic              tick, boundary;
    logic [FRAC_W-1:0] phase_n;
    logic [TMR_W-1:0]  tmr_q, tmr_n;
    logic [DUTY_W-1:0] fine_n;

    dbpwm_presc u_presc (
        .clk     (clk),
        .rst     (rst),
        .ctl_q   (tctl_q),
        .ps_n    (tctl_n.ps),
        .clr     (tmr_wr || tctl_wr),
        .tick    (tick),
        .phase_n (phase_n)
    );

    dbpwm_timebase u_tbase (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .tmr_wr   (tmr_wr),
        .per_wr   (per_wr),
        .flag_clr (fclr_wr),
        .wdata    (wr_data),
        .tmr_q    (tmr_q),
        .tmr_n    (tmr_n),
        .boundary (boundary),
        .flag_q   (period_flag)
    );

    assign fine_n = {tmr_n, phase_n};

    logic [NUM_CH-1:0][DUTY_W-1:0] act_all;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign duty_wr[c] = wr_en && (wr_addr == ADDR_W'(CH_BASE + 2 * c));
        assign ctl_wr[c]  = wr_en && (wr_addr == ADDR_W'(CH_BASE + 2 * c + 1));

        dbpwm_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .boundary (boundary),
            .duty_wr  (duty_wr[c]),
            .ctl_wr   (ctl_wr[c]),
            .wdata    (wr_data),
            .fine_n   (fine_n),
            .pwm_q    (pwm_out[c]),
            .act_q    (act_all[c])
        );
    end

endmodule

// File: rtl/dbpwm_chk.sv
module dbpwm_chk
    import dbpwm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [1:0]                    mode_bits,
    input logic [NUM_CH-1:0]             pwm_out,
    input logic                          period_flag,
    input logic                          boundary,
    input logic                          tmr_run,
    input logic [TMR_W-1:0]              tmr_q,
    input logic [NUM_CH-1:0][DUTY_W-1:0] act_all
);

    logic clr_wr, tmr_wr;
    assign clr_wr = wr_en && (wr_addr == ADDR_W'(ADR_FCLR));
    assign tmr_wr = wr_en && (wr_addr == ADDR_W'(ADR_TIMER));

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        boundary |=> period_flag);                                  // R4
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (period_flag && !clr_wr) |=> period_flag);                  // R4
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !boundary) |=> !period_flag);                    // R4
    AST_TMR_RESTART: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (tmr_q == '0));                                // R3
    AST_TMR_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!tmr_run && !tmr_wr) |=> $stable(tmr_q));                  // R2

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        AST_DUTY_BUFFERED: assert property (@(posedge clk) disable iff (rst)
            !boundary |=> $stable(act_all[c]));                     // R6
        AST_MODE_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr == ADDR_W'(CH_BASE + 2 * c + 1) && mode_bits != 2'b11)
            |=> !pwm_out[c]);                                       // R11
    end

endmodule

bind dbpwm_top dbpwm_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .mode_bits   (wr_data[3:2]),
    .pwm_out     (pwm_out),
    .period_flag (period_flag),
    .boundary    (boundary),
    .tmr_run     (tctl_q.run),
    .tmr_q       (tmr_q),
    .act_all     (act_all)
);

// File: tb/test_dbpwm_top.sv
`timescale 1ns/1ps
module test_dbpwm_top;

    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [3:0]     wr_addr = '0;
    logic [7:0]     wr_data = '0;
    logic [NCH-1:0] pwm_out;
    logic           period_flag;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dbpwm_top #(.NUM_CH(NCH), .ADDR_W(4)) i_dbpwm_top (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .pwm_out     (pwm_out),
        .period_flag (period_flag)
    );

    // ---------------- reference model (behavioural, cycle level) ----------------
    int m_tmr, m_ps, m_per, m_tc, m_flag;
    int m_db[NCH];
    int m_cc[NCH];
    int m_act[NCH];
    int m_out[NCH];

    function automatic int div_of(input int tc);
        if ((tc & 3) == 0) return 1;
        if ((tc & 3) == 1) return 4;
        return 16;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_tmr = 0; m_ps = 0; m_per = 0; m_tc = 0; m_flag = 0;
            for (int c = 0; c < NCH; c++) begin
                m_db[c] = 0; m_cc[c] = 0; m_act[c] = 0; m_out[c] = 0;
            end
        end else begin
            int  lim, ps_new, tmr_new, tc_new, fine_new;
            bit  twr, cwr, tick, bnd;
            twr  = wr_en && wr_addr == 0;
            cwr  = wr_en && wr_addr == 2;
            lim  = 4 * div_of(m_tc) - 1;
            tick = ((m_tc & 4) != 0) && !twr && !cwr && (m_ps == lim);
            if (twr || cwr)          ps_new = 0;
            else if ((m_tc & 4) == 0) ps_new = m_ps;
            else                      ps_new = (m_ps == lim) ? 0 : m_ps + 1;
            bnd = tick && (m_tmr == m_per);
            if (twr)       tmr_new = wr_data;
            else if (bnd)  tmr_new = 0;
            else if (tick) tmr_new = (m_tmr + 1) % 256;
            else           tmr_new = m_tmr;
            tc_new   = cwr ? (wr_data & 7) : m_tc;
            fine_new = tmr_new * 4 + (ps_new / div_of(tc_new)) % 4;
            if (bnd) m_flag = 1;
            else if (wr_en && wr_addr == 3) m_flag = 0;
            if (wr_en && wr_addr == 1) m_per = wr_data;
            for (int c = 0; c < NCH; c++) begin
                if (bnd) m_act[c] = m_db[c] * 4 + ((m_cc[c] >> 4) & 3);
                if (wr_en && wr_addr == 4 + 2 * c) m_db[c] = wr_data;
                if (wr_en && wr_addr == 5 + 2 * c) m_cc[c] = wr_data & 8'h3F;
                if (((m_cc[c] >> 2) & 3) != 3)    m_out[c] = 0;
                else if (fine_new == m_act[c])    m_out[c] = 0;
                else if (bnd)                     m_out[c] = 1;
            end
            m_tmr = tmr_new; m_ps = ps_new; m_tc = tc_new;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int c = 0; c < NCH; c++) begin
                nchk++;
                if (pwm_out[c] !== m_out[c][0]) begin
                    nerr++;
                    $display("FAIL R5 cycle compare ch%0d: actual=%b expected=%0d", c, pwm_out[c], m_out[c]);
                end
            end
            nchk++;
            if (period_flag !== m_flag[0]) begin
                nerr++;
                $display("FAIL R4 cycle compare flag: actual=%b expected=%0d", period_flag, m_flag);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rise(input int ch);
        while (pwm_out[ch]) @(negedge clk);
        while (!pwm_out[ch]) @(negedge clk);
    endtask

    task automatic measure(input int ch, output int hi, output int per);
        wait_rise(ch);
        hi = 0; per = 0;
        while (pwm_out[ch])  begin hi++; per++; @(negedge clk); end
        while (!pwm_out[ch]) begin per++; @(negedge clk); end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    // ---------------- directed scenario ----------------
    initial begin
        int hi, per, cnt, cnt_hi;
        repeat (4) @(negedge clk);
        chk("R1 reset pins", int'(pwm_out), 0);
        chk("R1 reset flag", int'(period_flag), 0);
        rst = 1'b0;
        @(negedge clk);

        // period 9, ch0 D = 4*4+2 = 18, ch1 D = 2*4 = 8, both PWM mode
        wr(1, 8'h09);
        wr(4, 8'h04); wr(5, 8'h2C);
        wr(6, 8'h02); wr(7, 8'h0C);
        repeat (20) @(negedge clk);
        chk("R1 stopped timer keeps pins low", int'(pwm_out), 0);

        wr(2, 8'h04);                      // run, prescale 1
        measure(0, hi, per);
        chk("R5 ch0 high time", hi, 18);
        chk("R3 cycle length prescale 1", per, 40);
        measure(1, hi, per);
        chk("R7 ch1 independent high time", hi, 8);

        // buffered duty: write mid-cycle, current cycle unchanged
        wait_rise(0);
        wr(4, 8'h01);                      // D becomes 6
        hi = 1;
        while (pwm_out[0]) begin hi++; @(negedge clk); end
        chk("R6 current cycle keeps old duty", hi, 18);
        measure(0, hi, per);
        chk("R6 next cycle uses new duty", hi, 6);

        // prescale 4 and 16
        wr(2, 8'h05);
        measure(0, hi, per);
        chk("R2 high time prescale 4", hi, 24);
        chk("R2 cycle length prescale 4", per, 160);
        wr(2, 8'h07);
        measure(0, hi, per);
        chk("R2 high time prescale 16", hi, 96);
        chk("R2 cycle length prescale 16", per, 640);
        wr(2, 8'h04);
        wr(4, 8'h04);                      // ch0 D back to 18

        // timer jump past ch1's duty point
        wait_rise(1);
        wait_rise(1);
        wr(0, 8'h03);                      // extended count becomes 12
        cnt = 1; cnt_hi = 0;
        while (pwm_out[0]) begin
            @(negedge clk); cnt++;
            if (!pwm_out[1]) cnt_hi++;
        end
        chk("R8 skipped channel stays high", int'(pwm_out[1]), 1);
        while (!pwm_out[0]) begin
            @(negedge clk); cnt++;
            if (!pwm_out[1]) cnt_hi++;
        end
        chk("R8 skipped channel never fell", cnt_hi, 0);
        chk("R8 clocks to next boundary after timer write", cnt, 29);

        // period limit written below the running count: wrap
        wait_rise(0);
        repeat (30) @(negedge clk);
        wr(1, 8'h03);
        cnt = 1;
        while (!pwm_out[0]) begin @(negedge clk); cnt++; end
        chk("R9 wrap before match", cnt, 1010);

        // new period 3 (16 clocks): ch0 D = 18 exceeds it
        cnt_hi = 0;
        for (int i = 0; i < 48; i++) begin
            if (pwm_out[0]) cnt_hi++;
            @(negedge clk);
        end
        chk("R10 duty above period stays high", cnt_hi, 48);
        measure(1, hi, per);
        chk("R9 new limit used at once", per, 16);
        chk("R7 ch1 high time in short period", hi, 8);

        // flag behaviour
        wait_rise(1);
        chk("R4 flag set after boundary", int'(period_flag), 1);
        wr(3, 0);
        chk("R4 flag cleared by write", int'(period_flag), 0);
        repeat (5) @(negedge clk);
        chk("R4 flag stays clear", int'(period_flag), 0);
        repeat (9) @(negedge clk);
        wr(3, 0);                          // clear lands on the boundary edge
        chk("R4 set wins over clear", int'(period_flag), 1);

        // zero duty on ch1
        wr(6, 8'h00);
        repeat (40) @(negedge clk);
        cnt_hi = 0;
        for (int i = 0; i < 48; i++) begin
            if (pwm_out[1]) cnt_hi++;
            @(negedge clk);
        end
        chk("R10 zero duty stays low", cnt_hi, 0);

        // mode off while high
        wr(6, 8'h02);
        repeat (40) @(negedge clk);
        wait_rise(1);
        wr(7, 8'h00);
        chk("R11 control 0 drives low", int'(pwm_out[1]), 0);
        chk("R7 other channel unaffected", int'(pwm_out[0]), 1);
        wr(7, 8'h08);
        cnt_hi = 0;
        for (int i = 0; i < 40; i++) begin
            if (pwm_out[1]) cnt_hi++;
            @(negedge clk);
        end
        chk("R11 mode 10xx stays low", cnt_hi, 0);

        // stop the timer: levels hold
        wr(7, 8'h0C);
        wait_rise(1);
        wr(2, 8'h00);
        repeat (100) @(negedge clk);
        chk("R2 stopped timer holds ch1 high", int'(pwm_out[1]), 1);

        done = 1;
        summary();
        $finish;
    end

endmodule